// File: doc/BRIEF.md
# UART Mode and Holding-Register Controller

This block is the control unit of a simple serial port. It holds no shift register and no baud timer. It keeps the state that the surrounding datapath consults. It runs four small machines side by side on one clock:

- a transmit-side mode machine and a receive-side mode machine, each switched between idle and active by its own bit in a control word;
- a transmit holding register with an empty or loaded status;
- a loopback selector that enters echo when both side enables are set.

A flag that reports a full receive FIFO is raised by a read-enable event and lowered by a FIFO read command.

The host writes data words into the holding register with a strobe. The transmit shifter takes the word with a read strobe. Every output is a register, so any input sampled at one rising edge appears on the outputs right after that edge. Reset is synchronous and active high.

Top module: `uart_mode_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `tx_active`=0, `rx_active`=0, `hold_loaded`=0, `hold_data`=0, `load_flag`=0, `fifo_full`=0 and `echo_active`=0.
- R2: After each edge, `tx_active` equals the value that `ctrl_reg` bit 2 had at that edge (1 = transmit, 0 = idle).
- R3: After each edge, `rx_active` equals the value that `ctrl_reg` bit 3 had at that edge (1 = receive, 0 = idle).
- R4: A `host_wr` pulse stores `host_data` in `hold_data` and sets both `hold_loaded` and `load_flag` to 1 after the edge.
- R5: A `shifter_rd` pulse while loaded, with no `host_wr`, makes `hold_loaded` and `load_flag` 0 after the edge.
- R6: When `host_wr` and `shifter_rd` share a cycle while loaded, the new word is stored and `hold_loaded` and `load_flag` stay 1.
- R7: A `shifter_rd` pulse while empty, with no `host_wr`, has no effect: `hold_loaded` stays 0 and `hold_data` keeps its value.
- R8: `rd_en_evt` sets `fifo_full` to 1 after the edge. `fifo_rd_cmd` alone clears it to 0. With neither input, it holds.
- R9: When `rd_en_evt` and `fifo_rd_cmd` share a cycle, `fifo_full` is 1 after the edge.
- R10: When `ctrl_reg` bits 3 and 2 are both 1 at an edge, `echo_active` is 1 after it.
- R11: When either `ctrl_reg` bit 2 or bit 3 is 0 at an edge, `echo_active` is 0 after it.
- R12: All machines advance on the same edge. A control-word change, a host write and a read-enable event given in one cycle all take effect together after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reg | input | CTRL_W (8) | Control word; bit 2 enables transmit, bit 3 enables receive |
| host_wr | input | 1 | Host write strobe for the holding register |
| host_data | input | DATA_W (8) | Data word written by the host |
| shifter_rd | input | 1 | Holding-register read strobe from the transmit shifter |
| rd_en_evt | input | 1 | Read-enable event; raises the FIFO-full flag |
| fifo_rd_cmd | input | 1 | FIFO read command; lowers the FIFO-full flag |
| tx_active | output | 1 | Transmit side in active mode |
| rx_active | output | 1 | Receive side in active mode |
| hold_loaded | output | 1 | Holding register status, 1 = loaded |
| hold_data | output | DATA_W (8) | Contents of the holding register |
| load_flag | output | 1 | Load flag presented to the transmitter |
| fifo_full | output | 1 | Receive FIFO-full flag |
| echo_active | output | 1 | Loopback echo mode selected |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the host write and the shifter read on a loaded holding register. The bench first loads a word. It then pulses both strobes in one cycle with a different data word. It judges the result by checking that the register reports loaded and holds the second word.

The second pair is the set and clear of the FIFO-full flag. The bench raises both commands together, once from the cleared state and once from the set state. It expects the flag to read 1 in both cases.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;

    typedef enum logic {
        SIDE_IDLE   = 1'b0,
        SIDE_ACTIVE = 1'b1
    } side_state_t;

    typedef enum logic {
        HOLD_EMPTY  = 1'b0,
        HOLD_LOADED = 1'b1
    } hold_state_t;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_ECHO   = 1'b1
    } loop_state_t;

endpackage

// File: rtl/side_mode_fsm.sv
module side_mode_fsm
    import uart_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic active
);
    typedef struct packed {
        side_state_t st;
    } side_regs_t;

    side_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            SIDE_IDLE:   if (enable)  r_d.st = SIDE_ACTIVE;
            SIDE_ACTIVE: if (!enable) r_d.st = SIDE_IDLE;
            default:     r_d.st = SIDE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: SIDE_IDLE};
        else     r_q <= r_d;
    end

    assign active = (r_q.st == SIDE_ACTIVE);

    // R2 / R3: the side mode follows its enable bit one edge later
    a_r2_r3_side_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (active == $past(enable)));

    a_r1_side_reset: assert property (@(posedge clk)
        rst |=> !active);
endmodule

// File: rtl/hold_reg_ctrl.sv
module hold_reg_ctrl
    import uart_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic              loaded,
    output logic              load_flag,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        hold_state_t       st;
        logic              flag;
        logic [DATA_W-1:0] word;
    } hold_regs_t;

    hold_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // A write always wins: it captures the word and keeps/sets loaded.
        if (wr) begin
            r_d.word = wdata;
            r_d.st   = HOLD_LOADED;
            r_d.flag = 1'b1;
        end else if (rd && r_q.st == HOLD_LOADED) begin
            r_d.st   = HOLD_EMPTY;
            r_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: HOLD_EMPTY, flag: 1'b0, word: '0};
        else     r_q <= r_d;
    end

    assign loaded    = (r_q.st == HOLD_LOADED);
    assign load_flag = r_q.flag;
    assign data      = r_q.word;

    a_r4_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr |=> (loaded && load_flag && data == $past(wdata)));

    a_r5_read_empties: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && loaded) |=> (!loaded && !load_flag));

    a_r6_write_read_collide: assert property (@(posedge clk) disable iff (rst)
        (rd && wr && loaded) |=> (loaded && data == $past(wdata)));

    a_r7_read_when_empty: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && !loaded) |=> (!loaded && $stable(data)));

    a_r1_hold_reset: assert property (@(posedge clk)
        rst |=> (!loaded && !load_flag && data == '0));
endmodule

// File: rtl/loop_mode_fsm.sv
module loop_mode_fsm
    import uart_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic rx_en,
    output logic echo
);
    typedef struct packed {
        loop_state_t st;
    } loop_regs_t;

    loop_regs_t r_d, r_q;
    logic both_en;

    assign both_en = tx_en & rx_en;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            MODE_NORMAL: if (both_en)  r_d.st = MODE_ECHO;
            MODE_ECHO:   if (!both_en) r_d.st = MODE_NORMAL;
            default:     r_d.st = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: MODE_NORMAL};
        else     r_q <= r_d;
    end

    assign echo = (r_q.st == MODE_ECHO);

    a_r10_echo_enter: assert property (@(posedge clk) disable iff (rst)
        (tx_en && rx_en) |=> echo);

    a_r11_echo_leave: assert property (@(posedge clk) disable iff (rst)
        (!tx_en || !rx_en) |=> !echo);

    a_r1_echo_reset: assert property (@(posedge clk)
        rst |=> !echo);
endmodule

// File: rtl/uart_mode_ctrl.sv
module uart_mode_ctrl
    import uart_mode_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CTRL_W     = 8,
    parameter int TX_EN_BIT  = 2,
    parameter int RX_EN_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_reg,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              shifter_rd,
    input  logic              rd_en_evt,
    input  logic              fifo_rd_cmd,
    output logic              tx_active,
    output logic              rx_active,
    output logic              hold_loaded,
    output logic [DATA_W-1:0] hold_data,
    output logic              load_flag,
    output logic              fifo_full,
    output logic              echo_active
);
    localparam int SIDES = 2;

    logic [SIDES-1:0] side_en;
    logic [SIDES-1:0] side_act;

    assign side_en[0] = ctrl_reg[TX_EN_BIT];
    assign side_en[1] = ctrl_reg[RX_EN_BIT];

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        side_mode_fsm u_side (
            .clk    (clk),
            .rst    (rst),
            .enable (side_en[g]),
            .active (side_act[g])
        );
    end

    assign tx_active = side_act[0];
    assign rx_active = side_act[1];

    hold_reg_ctrl #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr        (host_wr),
        .wdata     (host_data),
        .rd        (shifter_rd),
        .loaded    (hold_loaded),
        .load_flag (load_flag),
        .data      (hold_data)
    );

    loop_mode_fsm u_loop (
        .clk   (clk),
        .rst   (rst),
        .tx_en (side_en[0]),
        .rx_en (side_en[1]),
        .echo  (echo_active)
    );

    typedef struct packed {
        logic full;
    } fifo_regs_t;

    fifo_regs_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (rd_en_evt)        f_d.full = 1'b1;
        else if (fifo_rd_cmd) f_d.full = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '{full: 1'b0};
        else     f_q <= f_d;
    end

    assign fifo_full = f_q.full;

    a_r8_full_clear: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd_cmd && !rd_en_evt) |=> !fifo_full);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        rd_en_evt |=> fifo_full);

    a_r8_full_hold: assert property (@(posedge clk) disable iff (rst)
        (!fifo_rd_cmd && !rd_en_evt) |=> $stable(fifo_full));

    a_r1_full_reset: assert property (@(posedge clk)
        rst |=> !fifo_full);
endmodule

// File: tb/test_uart_mode_ctrl.sv
module test_uart_mode_ctrl;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [CTRL_W-1:0] ctrl_reg;
    logic              host_wr;
    logic [DATA_W-1:0] host_data;
    logic              shifter_rd;
    logic              rd_en_evt;
    logic              fifo_rd_cmd;
    logic              tx_active, rx_active, hold_loaded, load_flag, fifo_full, echo_active;
    logic [DATA_W-1:0] hold_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    uart_mode_ctrl #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_uart_mode_ctrl (
        .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .host_wr(host_wr),
        .host_data(host_data), .shifter_rd(shifter_rd), .rd_en_evt(rd_en_evt),
        .fifo_rd_cmd(fifo_rd_cmd), .tx_active(tx_active), .rx_active(rx_active),
        .hold_loaded(hold_loaded), .hold_data(hold_data), .load_flag(load_flag),
        .fifo_full(fifo_full), .echo_active(echo_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one edge: inputs already driven at negedge, results checked at next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        host_wr = 0; shifter_rd = 0; rd_en_evt = 0; fifo_rd_cmd = 0;
    endtask

    task automatic t_reset();
        rst = 1; ctrl_reg = 8'hFF; host_wr = 1; host_data = 8'h5A;
        rd_en_evt = 1; fifo_rd_cmd = 0; shifter_rd = 0;
        tick();
        tick();
        rst = 0; ctrl_reg = 8'h00;
        // R1: every output cleared
        chk("R1 tx", tx_active, 0);
        chk("R1 rx", rx_active, 0);
        chk("R1 loaded", hold_loaded, 0);
        chk("R1 data", hold_data, 0);
        chk("R1 flag", load_flag, 0);
        chk("R1 full", fifo_full, 0);
        chk("R1 echo", echo_active, 0);
    endtask

    task automatic t_sides();
        ctrl_reg = 8'h04; tick();
        chk("R2 tx on", tx_active, 1);
        chk("R3 rx off", rx_active, 0);
        chk("R11 echo off", echo_active, 0);
        ctrl_reg = 8'h08; tick();
        chk("R2 tx off", tx_active, 0);
        chk("R3 rx on", rx_active, 1);
        chk("R11 echo off rx only", echo_active, 0);
        ctrl_reg = 8'hF3; tick();
        chk("R2 other bits ignored", tx_active, 0);
        chk("R3 other bits ignored", rx_active, 0);
    endtask

    task automatic t_echo();
        ctrl_reg = 8'h0C; tick();
        chk("R10 echo on", echo_active, 1);
        chk("R2 tx with echo", tx_active, 1);
        ctrl_reg = 8'h08; tick();
        chk("R11 echo off bit2 low", echo_active, 0);
        ctrl_reg = 8'h0C; tick();
        chk("R10 echo again", echo_active, 1);
        ctrl_reg = 8'h04; tick();
        chk("R11 echo off bit3 low", echo_active, 0);
        ctrl_reg = 8'h00; tick();
    endtask

    task automatic t_hold();
        shifter_rd = 1; tick();
        chk("R7 read empty loaded", hold_loaded, 0);
        chk("R7 read empty data", hold_data, 0);
        host_wr = 1; host_data = 8'hA5; tick();
        chk("R4 loaded", hold_loaded, 1);
        chk("R4 flag", load_flag, 1);
        chk("R4 data", hold_data, 8'hA5);
        tick();
        chk("R4 holds", hold_loaded, 1);
        host_wr = 1; shifter_rd = 1; host_data = 8'h3C; tick();
        chk("R6 stays loaded", hold_loaded, 1);
        chk("R6 flag", load_flag, 1);
        chk("R6 new data", hold_data, 8'h3C);
        shifter_rd = 1; tick();
        chk("R5 empty", hold_loaded, 0);
        chk("R5 flag", load_flag, 0);
        shifter_rd = 1; host_data = 8'h77; tick();
        chk("R7 still empty", hold_loaded, 0);
        chk("R7 data kept", hold_data, 8'h3C);
        host_wr = 1; shifter_rd = 1; host_data = 8'h99; tick();
        chk("R6 write over empty read", hold_loaded, 1);
        chk("R6 data", hold_data, 8'h99);
        shifter_rd = 1; tick();
    endtask

    task automatic t_fifo();
        fifo_rd_cmd = 1; tick();
        chk("R8 clear while clear", fifo_full, 0);
        rd_en_evt = 1; fifo_rd_cmd = 1; tick();
        chk("R9 both from clear", fifo_full, 1);
        tick();
        chk("R8 holds", fifo_full, 1);
        rd_en_evt = 1; fifo_rd_cmd = 1; tick();
        chk("R9 both from set", fifo_full, 1);
        fifo_rd_cmd = 1; tick();
        chk("R8 cleared", fifo_full, 0);
        rd_en_evt = 1; tick();
        chk("R8 set", fifo_full, 1);
        fifo_rd_cmd = 1; tick();
    endtask

    task automatic t_concurrent();
        ctrl_reg = 8'h0C; host_wr = 1; host_data = 8'hE1; rd_en_evt = 1; tick();
        chk("R12 tx", tx_active, 1);
        chk("R12 rx", rx_active, 1);
        chk("R12 echo", echo_active, 1);
        chk("R12 hold", hold_data, 8'hE1);
        chk("R12 full", fifo_full, 1);
        ctrl_reg = 8'h00; shifter_rd = 1; fifo_rd_cmd = 1; tick();
        chk("R12 all idle", {tx_active, rx_active, echo_active, hold_loaded, fifo_full}, 0);
    endtask

    initial begin
        t_reset();
        t_sides();
        t_echo();
        t_hold();
        t_fifo();
        t_concurrent();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #40000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule